// File: doc/BRIEF.md
# Banked Predicate Register File

This block stores the one-bit predicates that guard instructions in a two-slot issue pipeline. The storage is split into sixteen banks of eight bits, and only one bank is visible at a time. A bank-select register chooses that bank. Decode can rewrite the select, and the new bank is seen by the instructions that follow.

Each issue slot has a read port that returns one predicate of the active bank. Each slot's compare has two single-bit write ports, one for the true result and one for the complement. A byte port can also overwrite the whole active bank. Every write meant for the active bank in a cycle is also merged onto the read path in that same cycle. This lets a decode-stage read see a result that execute is still producing.

Top module: `pred_bank_rf`

## Requirements
- R1: After reset the bank select is 0, and in every bank bit 0 reads 1 while bits 1 to 7 read 0.
- R2: The two read ports work independently. Read port p returns bit `rd_idx_i[3p+2:3p]` of the active bank, after forwarding.
- R3: An enabled single-bit write port stores its value in the active bank at the clock edge. Later reads return that value.
- R4: When a read index matches an enabled single-bit write in the same cycle, the read returns the value being written, not the stored one.
- R5: When several enabled single-bit ports target the same bit, the port with the highest number wins, both for the stored value and for the forwarded value. Ports 2 and 3 belong to slot 1 and ports 0 and 1 to slot 0, so slot 1 wins over slot 0.
- R6: An asserted byte write replaces all eight bits of the active bank with `byte_i` (bit i comes from `byte_i[i]`). The new value is forwarded to the reads in the same cycle.
- R7: When a byte write and single-bit writes occur in the same cycle, the single-bit writes override the byte value for the bits they target.
- R8: When `bsel_we_i` is high, the select takes `bsel_i` from the next cycle on. Reads and writes in the cycle of the update still use the old bank.
- R9: Writes change only the active bank. All other banks keep their contents.
- R10: A write port whose enable is low has no effect, whatever its index and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bsel_we_i | input | 1 | Load a new bank select |
| bsel_i | input | 4 | New bank select value |
| bw_en_i | input | 4 | Enables of the single-bit write ports |
| bw_idx_i | input | 12 | Bit index of each write port, 3 bits per port |
| bw_val_i | input | 4 | Data of each write port |
| byte_we_i | input | 1 | Byte write enable |
| byte_i | input | 8 | Byte write data |
| rd_idx_i | input | 6 | Bit index of each read port, 3 bits per port |
| rd_val_o | output | 2 | Predicate value of each read port |

## Verification
The bench uses the default parameters: sixteen banks of eight bits, four single-bit write ports and two read ports. With these values the last bank (select 15) can be reached, and all four write ports can collide on one bit. A full bank can be read back through both read ports in four index steps. A bank switch in the same cycle as a write is tested, to show which bank receives the write and which bank the reads see.

// File: rtl/pred_rf_pkg.sv
package pred_rf_pkg;
  localparam int unsigned DEF_BANKS    = 16;
  localparam int unsigned DEF_BITS     = 8;
  localparam int unsigned DEF_WR_PORTS = 4;
  localparam int unsigned DEF_RD_PORTS = 2;
  // index of the always-true predicate preset at reset
  localparam int unsigned TRUE_BIT     = 0;
endpackage

// File: rtl/pred_bank_sel.sv
module pred_bank_sel #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_o <= '0;
    else if (we_i) sel_o <= sel_i;
  end
endmodule

// File: rtl/pred_wr_merge.sv
module pred_wr_merge #(
  parameter int unsigned BITS  = 8,
  parameter int unsigned PORTS = 4,
  localparam int unsigned IDX_W = $clog2(BITS)
) (
  input  logic [BITS-1:0]        cur_i,
  input  logic                   byte_we_i,
  input  logic [BITS-1:0]        byte_i,
  input  logic [PORTS-1:0]       en_i,
  input  logic [PORTS*IDX_W-1:0] idx_i,
  input  logic [PORTS-1:0]       val_i,
  output logic [BITS-1:0]        merged_o,
  output logic                   upd_o
);
  always_comb begin
    merged_o = byte_we_i ? byte_i : cur_i;
    // ascending order: the highest-numbered port lands last
    for (int p = 0; p < int'(PORTS); p++) begin
      if (en_i[p]) merged_o[idx_i[p*IDX_W +: IDX_W]] = val_i[p];
    end
    upd_o = byte_we_i | (|en_i);
  end
endmodule

// File: rtl/pred_bank_store.sv
module pred_bank_store #(
  parameter int unsigned BANKS = 16,
  parameter int unsigned BITS  = 8,
  parameter int unsigned TBIT  = 0,
  localparam int unsigned SEL_W = $clog2(BANKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             upd_i,
  input  logic [BITS-1:0]  wdata_i,
  output logic [BITS-1:0]  rdata_o
);
  localparam logic [BITS-1:0] RST_VAL = BITS'(1) << TBIT;

  logic [BITS-1:0] bank_q [BANKS];

  for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            bank_q[b] <= RST_VAL;
      else if (upd_i && sel_i == SEL_W'(b))   bank_q[b] <= wdata_i;
    end
  end

  assign rdata_o = bank_q[sel_i];
endmodule

// File: rtl/pred_rd_port.sv
module pred_rd_port #(
  parameter int unsigned BITS = 8,
  localparam int unsigned IDX_W = $clog2(BITS)
) (
  input  logic [BITS-1:0]  bank_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             val_o
);
  assign val_o = bank_i[idx_i];
endmodule

// File: rtl/pred_bank_rf.sv
module pred_bank_rf
  import pred_rf_pkg::*;
#(
  parameter int unsigned NUM_BANKS = DEF_BANKS,
  parameter int unsigned BANK_BITS = DEF_BITS,
  parameter int unsigned NUM_WR    = DEF_WR_PORTS,
  parameter int unsigned NUM_RD    = DEF_RD_PORTS,
  localparam int unsigned IDX_W    = $clog2(BANK_BITS),
  localparam int unsigned SEL_W    = $clog2(NUM_BANKS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bsel_we_i,
  input  logic [SEL_W-1:0]        bsel_i,
  input  logic [NUM_WR-1:0]       bw_en_i,
  input  logic [NUM_WR*IDX_W-1:0] bw_idx_i,
  input  logic [NUM_WR-1:0]       bw_val_i,
  input  logic                    byte_we_i,
  input  logic [BANK_BITS-1:0]    byte_i,
  input  logic [NUM_RD*IDX_W-1:0] rd_idx_i,
  output logic [NUM_RD-1:0]       rd_val_o
);
  logic [SEL_W-1:0]     bsel_q;
  logic [BANK_BITS-1:0] cur_bank;
  logic [BANK_BITS-1:0] merged;
  logic                 upd;

  pred_bank_sel #(.SEL_W(SEL_W)) i_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (bsel_we_i),
    .sel_i (bsel_i),
    .sel_o (bsel_q)
  );

  pred_bank_store #(
    .BANKS(NUM_BANKS),
    .BITS (BANK_BITS),
    .TBIT (TRUE_BIT)
  ) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (bsel_q),
    .upd_i  (upd),
    .wdata_i(merged),
    .rdata_o(cur_bank)
  );

  pred_wr_merge #(
    .BITS (BANK_BITS),
    .PORTS(NUM_WR)
  ) i_merge (
    .cur_i    (cur_bank),
    .byte_we_i(byte_we_i),
    .byte_i   (byte_i),
    .en_i     (bw_en_i),
    .idx_i    (bw_idx_i),
    .val_i    (bw_val_i),
    .merged_o (merged),
    .upd_o    (upd)
  );

  // reads see the merged image: same-cycle forwarding
  for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rd
    pred_rd_port #(.BITS(BANK_BITS)) i_rd (
      .bank_i(merged),
      .idx_i (rd_idx_i[r*IDX_W +: IDX_W]),
      .val_o (rd_val_o[r])
    );
  end
endmodule

// File: rtl/pred_bank_rf_chk.sv
module pred_bank_rf_chk #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned BANK_BITS = 8,
  parameter int unsigned NUM_WR    = 4,
  parameter int unsigned NUM_RD    = 2,
  localparam int unsigned IDX_W    = $clog2(BANK_BITS),
  localparam int unsigned SEL_W    = $clog2(NUM_BANKS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    bsel_we_i,
  input logic [SEL_W-1:0]        bsel_i,
  input logic [NUM_WR-1:0]       bw_en_i,
  input logic [NUM_WR*IDX_W-1:0] bw_idx_i,
  input logic [NUM_WR-1:0]       bw_val_i,
  input logic                    byte_we_i,
  input logic [BANK_BITS-1:0]    byte_i,
  input logic [NUM_RD*IDX_W-1:0] rd_idx_i,
  input logic [NUM_RD-1:0]       rd_val_o,
  input logic [SEL_W-1:0]        bsel_q
);
  logic [IDX_W-1:0] rd0_idx, top_idx;
  assign rd0_idx = rd_idx_i[IDX_W-1:0];
  assign top_idx = bw_idx_i[NUM_WR*IDX_W-1 -: IDX_W];

  // R4
  fwd_top_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_en_i[NUM_WR-1] && rd0_idx == top_idx) |-> rd_val_o[0] == bw_val_i[NUM_WR-1]);

  // R3
  store_top_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bw_en_i[NUM_WR-1] && !bsel_we_i) |=>
      (rd0_idx != $past(top_idx) || bw_en_i != '0 || byte_we_i ||
       rd_val_o[0] == $past(bw_val_i[NUM_WR-1])));

  // R6
  byte_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && bw_en_i == '0) |-> rd_val_o[0] == byte_i[rd0_idx]);

  // R8
  bsel_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsel_we_i |=> bsel_q == $past(bsel_i));

  // R8
  bsel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bsel_we_i |=> $stable(bsel_q));

  // R10
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bw_en_i) == '0 && !$past(byte_we_i) && !$past(bsel_we_i) &&
     bw_en_i == '0 && !byte_we_i && $stable(rd_idx_i)) |-> $stable(rd_val_o));
endmodule

bind pred_bank_rf pred_bank_rf_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_BITS(BANK_BITS),
  .NUM_WR   (NUM_WR),
  .NUM_RD   (NUM_RD)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bsel_we_i(bsel_we_i),
  .bsel_i   (bsel_i),
  .bw_en_i  (bw_en_i),
  .bw_idx_i (bw_idx_i),
  .bw_val_i (bw_val_i),
  .byte_we_i(byte_we_i),
  .byte_i   (byte_i),
  .rd_idx_i (rd_idx_i),
  .rd_val_o (rd_val_o),
  .bsel_q   (bsel_q)
);

// File: tb/test_pred_bank_rf.sv
`timescale 1ns/1ps
module test_pred_bank_rf;
  localparam int NB = 16, BW = 8, NW = 4, NR = 2;
  localparam int IW = $clog2(BW), SW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bsel_we;
  logic [SW-1:0] bsel;
  logic [NW-1:0] bw_en, bw_val;
  logic [NW*IW-1:0] bw_idx;
  logic byte_we;
  logic [BW-1:0] byte_d;
  logic [NR*IW-1:0] rd_idx;
  logic [NR-1:0] rd_val;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pred_bank_rf i_pred_bank_rf (
    .clk_i(clk), .rst_ni(rst_n), .bsel_we_i(bsel_we), .bsel_i(bsel),
    .bw_en_i(bw_en), .bw_idx_i(bw_idx), .bw_val_i(bw_val),
    .byte_we_i(byte_we), .byte_i(byte_d), .rd_idx_i(rd_idx), .rd_val_o(rd_val)
  );

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bsel_we = 1'b0; bsel = '0; bw_en = '0; bw_idx = '0; bw_val = '0;
    byte_we = 1'b0; byte_d = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic set_bw(input int p, input int ix, input logic v);
    bw_en[p] = 1'b1;
    bw_idx[p*IW +: IW] = IW'(ix);
    bw_val[p] = v;
  endtask

  task automatic get_rd(input int p, input int ix, output logic v);
    rd_idx[p*IW +: IW] = IW'(ix);
    #0.5;
    v = rd_val[p];
  endtask

  task automatic read_bank(output logic [BW-1:0] v);
    for (int i = 0; i < BW; i += 2) begin
      rd_idx = {IW'(i + 1), IW'(i)};
      #0.4;
      v[i] = rd_val[0];
      v[i+1] = rd_val[1];
    end
  endtask

  task automatic switch_bank(input int b);
    bsel_we = 1'b1; bsel = SW'(b);
    tick();
  endtask

  task automatic t_reset();
    logic [BW-1:0] v;
    read_bank(v); chk("R1 bank0", v, 8'h01);
    switch_bank(15);
    read_bank(v); chk("R1 bank15", v, 8'h01);
    switch_bank(0);
  endtask

  task automatic t_bit_write();
    logic [BW-1:0] v;
    logic a, b;
    set_bw(0, 5, 1'b1); set_bw(1, 0, 1'b0);
    tick();
    read_bank(v); chk("R3 stored", v, 8'h20);
    rd_idx = {IW'(0), IW'(5)};
    #0.5;
    chk("R2 port0", {7'd0, rd_val[0]}, 8'h01);
    chk("R2 port1", {7'd0, rd_val[1]}, 8'h00);
    get_rd(1, 5, b); get_rd(0, 4, a);
    chk("R2 swapped", {6'd0, b, a}, 8'h02);
  endtask

  task automatic t_forward();
    logic a, b;
    logic [BW-1:0] v;
    set_bw(2, 3, 1'b1);
    get_rd(0, 3, a); get_rd(1, 4, b);
    chk("R4 fwd", {6'd0, b, a}, 8'h01);
    tick();
    read_bank(v); chk("R4 committed", v, 8'h28);
  endtask

  task automatic t_priority();
    logic a;
    logic [BW-1:0] v;
    set_bw(0, 7, 1'b0); set_bw(1, 7, 1'b1); set_bw(2, 7, 1'b0); set_bw(3, 7, 1'b1);
    get_rd(0, 7, a); chk("R5 fwd port3", {7'd0, a}, 8'h01);
    tick();
    read_bank(v); chk("R5 store port3", v, 8'hA8);
    set_bw(0, 7, 1'b1); set_bw(1, 7, 1'b0);
    get_rd(1, 7, a); chk("R5 fwd port1 over 0", {7'd0, a}, 8'h00);
    tick();
    read_bank(v); chk("R5 store port1 over 0", v, 8'h28);
  endtask

  task automatic t_byte();
    logic a, b;
    logic [BW-1:0] v;
    byte_we = 1'b1; byte_d = 8'h3C;
    get_rd(0, 2, a); get_rd(1, 6, b);
    chk("R6 fwd", {6'd0, b, a}, 8'h01);
    tick();
    read_bank(v); chk("R6 stored", v, 8'h3C);
    byte_we = 1'b1; byte_d = 8'hA5; set_bw(1, 1, 1'b1); set_bw(3, 7, 1'b0);
    get_rd(0, 1, a); get_rd(1, 7, b);
    chk("R7 fwd", {6'd0, b, a}, 8'h01);
    tick();
    read_bank(v); chk("R7 stored", v, 8'h27);
    byte_we = 1'b1; byte_d = 8'h3C;
    tick();
  endtask

  task automatic t_switch();
    logic a, b;
    logic [BW-1:0] v;
    bsel_we = 1'b1; bsel = SW'(9); set_bw(0, 2, 1'b0);
    get_rd(0, 2, a); get_rd(1, 3, b);
    chk("R8 old bank in switch cycle", {6'd0, b, a}, 8'h02);
    tick();
    read_bank(v); chk("R8 new bank", v, 8'h01);
    byte_we = 1'b1; byte_d = 8'hF0;
    tick();
    switch_bank(0);
    read_bank(v); chk("R9 bank0 kept", v, 8'h38);
    switch_bank(9);
    read_bank(v); chk("R9 bank9 kept", v, 8'hF0);
  endtask

  task automatic t_disabled();
    logic a;
    logic [BW-1:0] v;
    bw_en = '0; bw_idx = '1; bw_val = '1; byte_we = 1'b0; byte_d = '1;
    get_rd(0, 0, a); chk("R10 no fwd", {7'd0, a}, 8'h00);
    @(negedge clk);
    read_bank(v); chk("R10 no store", v, 8'hF0);
    idle();
    switch_bank(0);
    read_bank(v); chk("R10 other bank", v, 8'h38);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit_write();
    t_forward();
    t_priority();
    t_byte();
    t_switch();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule